// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments into a descriptor table for a bus-master disk DMA engine. Each segment is a 32-bit bus address and a byte length. It arrives on a valid/ready handshake, and a flag marks the final segment of a list. For each region the block writes a two-word entry through a plain word-write port. The entries go to consecutive word addresses, starting at a base word address that is sampled when the list begins.

No entry may cross a 64 KB address boundary. In normal mode the block never emits a zero count field. A full 64 KB piece becomes two 32 KB entries, because some controllers read a zero count as zero bytes. The count word of the final entry carries an end-of-table mark.

A second count encoding serves a controller variant that needs 32-bit alignment. When a list would need more entries than the table holds, or when it holds no bytes at all, the block reports failure. The request can then fall back to programmed I/O. A one-cycle completion pulse carries the success flag and the entry count.

Top module: `prd_table_builder`

## Requirements
- R1: After reset the block is ready for a segment (`seg_ready`=1), and both `wr_en` and `done` are 0.
- R2: Entry k of a list is written as two words. Its address word goes to word address base+2k and its count word to base+2k+1, where base is `cfg_base` sampled at the first segment. Each word is stored with bit 0 as the least significant bit of byte lane 0 (little-endian).
- R3: A segment is cut into pieces. Each piece is the smaller of the bytes left and (0x10000 minus the low 16 bits of the current address), so no entry crosses a 64 KB boundary. In normal mode a count word holds the byte count in bits 15:0.
- R4: In normal mode, a piece of exactly 0x10000 bytes is written as two entries of 0x8000 bytes each, at the address and at the address plus 0x8000. No count field is ever 0x0000.
- R5: In normal mode (`cfg_alt`=0), bit 31 of the count word of the last entry is set, and bit 31 is clear in every other count word.
- R6: In alternate mode (`cfg_alt`=1), a count word is ((bytes>>2)-1) in bits 31:16 with bits 15:0 zero. A 64 KB piece stays one entry, and no end mark is set.
- R7: If a list needs more than CAP entries, counting both halves of a split 64 KB piece, the block reports `ok`=0. It discards the remaining segments up to the one flagged last.
- R8: A list whose segments all have zero length reports `ok`=0 and an entry count of 0.
- R9: Segments of zero length produce no entry and do not change the other entries.
- R10: `done` is a single-cycle pulse. In that cycle, `ok` is 1 on success, and `entry_count` gives the number of entries built (0 on failure).
- R11: `seg_ready` stays low from the acceptance of a segment until that segment's entries are written. It stays low from the last segment until `done`. A new list is accepted after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Word address of entry 0, sampled at the first segment of a list |
| cfg_alt | input | 1 | Selects alternate count encoding, sampled at the first segment |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high together with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the list |
| wr_en | output | 1 | Table word write strobe |
| wr_addr | output | AW | Table word address |
| wr_data | output | 32 | Table word value |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Table built successfully |
| entry_count | output | $clog2(CAP+1) | Number of entries built |

## Verification
On every cycle, the assertions check several properties:
- no piece being written crosses a 64 KB boundary;
- no normal-mode count field is zero;
- the entry count never passes the capacity;
- no segment is taken while a word is being written;
- `done` lasts one cycle, and an empty list never reports success.

Only the bench's scenarios can show that the words land at the right addresses with the right values. The same holds for the end mark sitting on exactly the last entry and for the two halves of a 64 KB piece. Overflow at the exact capacity edge, draining after an abort, and the skipping of zero-length segments likewise need the bench's scenarios.

// File: rtl/prd_pkg.sv
package prd_pkg;
    typedef enum logic [2:0] {
        S_FETCH,
        S_ADDR,
        S_CNT,
        S_FIX,
        S_DRAIN,
        S_DONE
    } prd_state_e;

    localparam logic [16:0] BOUNDARY = 17'h10000;
    localparam logic [16:0] HALF     = 17'h08000;
    localparam logic [31:0] END_MARK = 32'h8000_0000;
endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc #(
    parameter int LEN_W = 24
) (
    input  logic [15:0]      addr_lo,
    input  logic [LEN_W-1:0] remain,
    input  logic             alt,
    output logic [16:0]      chunk
);
    import prd_pkg::*;

    logic [16:0]      room;
    logic [LEN_W-1:0] room_w;
    logic [LEN_W-1:0] take_w;

    always_comb begin
        room   = BOUNDARY - {1'b0, addr_lo};
        room_w = LEN_W'(room);
        take_w = (remain < room_w) ? remain : room_w;
        chunk  = take_w[16:0];
        // a full 64 KB piece is emitted as halves in normal mode
        if (!alt && chunk == BOUNDARY)
            chunk = HALF;
    end
endmodule

// File: rtl/prd_count_enc.sv
module prd_count_enc (
    input  logic [16:0] chunk,
    input  logic        alt,
    output logic [31:0] word
);
    logic [16:0] quads_m1;

    always_comb begin
        quads_m1 = (chunk >> 2) - 17'd1;
        if (alt)
            word = {quads_m1[15:0], 16'h0000};
        else
            word = {16'h0000, chunk[15:0]};
    end
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder #(
    parameter int CAP   = 256,
    parameter int LEN_W = 24,
    parameter int AW    = 16,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_base,
    input  logic             cfg_alt,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic             done,
    output logic             ok,
    output logic [CNT_W-1:0] entry_count
);
    import prd_pkg::*;

    typedef struct packed {
        prd_state_e       st;
        logic [31:0]      addr;
        logic [LEN_W-1:0] rem;
        logic [16:0]      chunk;
        logic             last;
        logic             alt;
        logic             active;
        logic [AW-1:0]    ptr;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      lastw;
        logic             ok;
    } regs_t;

    regs_t q, d;

    logic [16:0] chunk_now;
    logic [31:0] cnt_word;

    prd_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo (q.addr[15:0]),
        .remain  (q.rem),
        .alt     (q.alt),
        .chunk   (chunk_now)
    );

    prd_count_enc u_enc (
        .chunk (q.chunk),
        .alt   (q.alt),
        .word  (cnt_word)
    );

    function automatic prd_state_e finish_st(input logic [CNT_W-1:0] n, input logic alt);
        return (n == '0 || alt) ? S_DONE : S_FIX;
    endfunction

    always_comb begin
        logic [CNT_W-1:0] n_now;
        logic             alt_now;
        d         = q;
        seg_ready = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = q.ptr;
        wr_data   = '0;
        done      = 1'b0;
        n_now     = q.active ? q.cnt : '0;
        alt_now   = q.active ? q.alt : cfg_alt;
        case (q.st)
            S_FETCH: begin
                seg_ready = 1'b1;
                if (seg_valid) begin
                    if (!q.active) begin
                        d.active = 1'b1;
                        d.alt    = cfg_alt;
                        d.ptr    = cfg_base;
                        d.cnt    = '0;
                    end
                    if (seg_len == '0) begin
                        if (seg_last) begin
                            d.st = finish_st(n_now, alt_now);
                            d.ok = (n_now != '0) && alt_now;
                        end
                    end else begin
                        d.addr = seg_addr;
                        d.rem  = seg_len;
                        d.last = seg_last;
                        d.st   = S_ADDR;
                    end
                end
            end
            S_ADDR: begin
                if (q.cnt == CNT_W'(CAP)) begin
                    d.ok = 1'b0;
                    d.st = q.last ? S_DONE : S_DRAIN;
                end else begin
                    wr_en   = 1'b1;
                    wr_data = q.addr;
                    d.ptr   = q.ptr + AW'(1);
                    d.chunk = chunk_now;
                    d.st    = S_CNT;
                end
            end
            S_CNT: begin
                wr_en   = 1'b1;
                wr_data = cnt_word;
                d.lastw = cnt_word;
                d.ptr   = q.ptr + AW'(1);
                d.cnt   = q.cnt + CNT_W'(1);
                d.addr  = q.addr + 32'(q.chunk);
                d.rem   = q.rem - LEN_W'(q.chunk);
                if (q.rem == LEN_W'(q.chunk)) begin
                    if (q.last) begin
                        d.st = finish_st(q.cnt + CNT_W'(1), q.alt);
                        d.ok = q.alt;
                    end else begin
                        d.st = S_FETCH;
                    end
                end else begin
                    d.st = S_ADDR;
                end
            end
            S_FIX: begin
                wr_en   = 1'b1;
                wr_addr = q.ptr - AW'(1);
                wr_data = q.lastw | END_MARK;
                d.ok    = 1'b1;
                d.st    = S_DONE;
            end
            S_DRAIN: begin
                seg_ready = 1'b1;
                if (seg_valid && seg_last)
                    d.st = S_DONE;
            end
            S_DONE: begin
                done     = 1'b1;
                d.active = 1'b0;
                d.st     = S_FETCH;
            end
            default: d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ok          = q.ok;
    assign entry_count = q.ok ? q.cnt : '0;

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CNT) |-> ({2'b00, q.addr[15:0]} + {1'b0, q.chunk}) <= 18'h10000); // R3
    AST_NZ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.st == S_CNT && !q.alt) |-> (wr_data[15:0] != 16'h0000)); // R4
    AST_ALT_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.st == S_CNT && q.alt) |-> !wr_data[31] && wr_data[15:0] == 16'h0); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(CAP)); // R7
    AST_EMPTY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.cnt == '0) |-> !ok); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |-> !wr_en && !done); // R11
endmodule

// File: tb/test_prd_table_builder.sv
module test_prd_table_builder;
    localparam int CAP   = 8;
    localparam int LEN_W = 24;
    localparam int AW    = 16;
    localparam int CW    = $clog2(CAP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0]    cfg_base = '0;
    logic             cfg_alt = 1'b0;
    logic             seg_valid = 1'b0;
    logic             seg_ready;
    logic [31:0]      seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic             seg_last = 1'b0;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [31:0]      wr_data;
    logic             done, ok;
    logic [CW-1:0]    entry_count;

    prd_table_builder #(.CAP(CAP), .LEN_W(LEN_W), .AW(AW)) i_prd_table_builder (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_alt(cfg_alt),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .ok(ok), .entry_count(entry_count)
    );

    logic [31:0] mem [256];
    logic clr = 1'b0;
    always @(posedge clk) begin
        if (clr) for (int k = 0; k < 256; k++) mem[k] <= 32'hA5A5_A5A5;
        else if (wr_en) mem[wr_addr[7:0]] <= wr_data;
    end

    int checks = 0;
    int fails = 0;
    logic [31:0]      sa [8];
    logic [LEN_W-1:0] sl [8];
    logic [31:0]      ea [16];
    logic [31:0]      ew [16];
    int               en;
    bit               eok;
    logic             got_ok;
    logic [CW-1:0]    got_cnt;

    // single-segment vectors: address, length, mode, expected entries, expected ok
    localparam int NV = 9;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0001_F000, 32'h0002_0000,
        32'h0003_0000, 32'h0004_FFF0, 32'h0001_0000, 32'h0000_F000, 32'h0000_0000, 32'h0000_0000};
    localparam logic [23:0] V_LEN [NV] = '{24'h200, 24'h2000, 24'h10000, 24'h20000,
        24'h10010, 24'h10000, 24'h2000, 24'h50000, 24'h40000};
    localparam bit V_ALT [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_N   [NV] = '{1, 2, 2, 4, 3, 1, 2, 0, 8};
    localparam bit V_OK  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
    string v_tag [NV] = '{"R2", "R3", "R4", "R4", "R3", "R6", "R6", "R7", "R5"};

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // reference table built from the requirements
    task automatic model(input int n, input bit alt);
        longint a, l, b;
        en = 0;
        eok = 1;
        for (int i = 0; i < n && eok; i++) begin
            a = longint'(sa[i]);
            l = longint'(sl[i]);
            while (l > 0 && eok) begin
                b = 64'h10000 - (a & 64'hFFFF);
                if (b > l) b = l;
                if (!alt && b == 64'h10000) begin
                    if (en + 2 > CAP) eok = 0;
                    else begin
                        ea[en] = 32'(a);            ew[en] = 32'h8000;
                        ea[en+1] = 32'(a + 'h8000); ew[en+1] = 32'h8000;
                        en += 2;
                    end
                end else if (en + 1 > CAP) eok = 0;
                else begin
                    ea[en] = 32'(a);
                    ew[en] = alt ? ({16'(((b >> 2) - 1)), 16'h0}) : 32'(b);
                    en++;
                end
                a += b;
                l -= b;
            end
        end
        if (en == 0) eok = 0;
        if (eok && !alt) ew[en-1] = ew[en-1] | 32'h8000_0000;
    endtask

    task automatic run_list(input int n, input bit alt, input logic [AW-1:0] base);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        cfg_base = base;
        cfg_alt  = alt;
        for (int i = 0; i < n; i++) begin
            seg_valid = 1'b1;
            seg_addr  = sa[i];
            seg_len   = sl[i];
            seg_last  = (i == n - 1);
            while (!seg_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        seg_valid = 1'b0;
        while (!done) @(negedge clk);
        got_ok  = ok;
        got_cnt = entry_count;
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", 32'(done), 32'h0);
    endtask

    task automatic verify(input logic [AW-1:0] base, input string tag);
        chk(got_ok == eok, {tag, " ok flag"}, 32'(got_ok), 32'(eok));
        chk(got_cnt == (eok ? CW'(en) : '0), "R10 entry_count", 32'(got_cnt), eok ? 32'(en) : 0);
        if (eok) begin
            for (int k = 0; k < en; k++) begin
                chk(mem[8'(base) + 8'(2*k)] == ea[k], {tag, " R2 address word"}, mem[8'(base) + 8'(2*k)], ea[k]);
                chk(mem[8'(base) + 8'(2*k+1)] == ew[k], {tag, " count word"}, mem[8'(base) + 8'(2*k+1)], ew[k]);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(seg_ready == 1'b1, "R1 seg_ready after reset", 32'(seg_ready), 32'h1);
        chk(wr_en == 1'b0, "R1 wr_en after reset", 32'(wr_en), 32'h0);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 32'h0);

        for (int v = 0; v < NV; v++) begin
            sa[0] = V_ADDR[v];
            sl[0] = V_LEN[v];
            model(1, V_ALT[v]);
            chk(en == V_N[v] || !V_OK[v], {v_tag[v], " table entry count"}, 32'(en), 32'(V_N[v]));
            chk(eok == V_OK[v], {v_tag[v], " table ok"}, 32'(eok), 32'(V_OK[v]));
            run_list(1, V_ALT[v], AW'(16 + 4 * v));
            verify(AW'(16 + 4 * v), v_tag[v]);
        end

        // R9: zero-length segments skipped, including a zero-length last one
        sa[0] = 32'h1000; sl[0] = 0;
        sa[1] = 32'h2000; sl[1] = 24'h100;
        sa[2] = 32'h3000; sl[2] = 0;
        sa[3] = 32'h4000; sl[3] = 24'h80;
        sa[4] = 32'h5000; sl[4] = 0;
        model(5, 1'b0);
        run_list(5, 1'b0, AW'(8));
        verify(AW'(8), "R9");
        chk(got_cnt == CW'(2), "R9 two entries", 32'(got_cnt), 32'h2);

        // R8: empty lists
        sa[0] = 32'h1000; sl[0] = 0;
        run_list(1, 1'b0, AW'(8));
        chk(got_ok == 1'b0, "R8 single empty ok", 32'(got_ok), 32'h0);
        chk(got_cnt == '0, "R8 single empty count", 32'(got_cnt), 32'h0);
        sl[1] = 0;
        run_list(2, 1'b1, AW'(8));
        chk(got_ok == 1'b0, "R8 double empty ok", 32'(got_ok), 32'h0);

        // R7: split extra entry overflows; trailing segments drained
        sa[0] = 32'h0;        sl[0] = 24'h38000;
        sa[1] = 32'h10_0000;  sl[1] = 24'h10000;
        sa[2] = 32'h20_0000;  sl[2] = 24'h10;
        model(3, 1'b0);
        chk(eok == 1'b0, "R7 model overflow", 32'(eok), 32'h0);
        run_list(3, 1'b0, AW'(8));
        chk(got_ok == 1'b0, "R7 split overflow ok", 32'(got_ok), 32'h0);
        chk(seg_ready == 1'b1, "R7 ready after drain", 32'(seg_ready), 32'h1);

        // R11: ready low while building; recovers for a new list
        @(negedge clk);
        cfg_base = AW'(100); cfg_alt = 1'b0;
        seg_valid = 1'b1; seg_addr = 32'h7000; seg_len = 24'h40; seg_last = 1'b1;
        @(posedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
        chk(seg_ready == 1'b0, "R11 busy ready low", 32'(seg_ready), 32'h0);
        chk(wr_en && wr_addr == AW'(100), "R2 first write at base", 32'(wr_addr), 32'd100);
        chk(wr_data == 32'h7000, "R2 first word is address", wr_data, 32'h7000);
        @(negedge clk);
        chk(seg_ready == 1'b0, "R11 ready low on count word", 32'(seg_ready), 32'h0);
        chk(wr_data == 32'h40, "R3 count word low bits", wr_data, 32'h40);
        while (!done) @(negedge clk);
        chk(ok == 1'b1 && entry_count == CW'(1), "R11 new list after abort", 32'(entry_count), 32'h1);
        chk(mem[101] == 32'h8000_0040, "R5 end mark", mem[101], 32'h8000_0040);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule